// File: doc/BRIEF.md
# Auto-Increment Configuration RAM Port

This block lets a host processor load and inspect a small configuration RAM through one data register. An internal address pointer steps forward by one location after every host read or write, so a whole lookup table can be streamed in or out as a single burst after power-up. The pointer returns to zero after the last location. A separate pointer-clear strobe sends it back to location zero.

The RAM has one address port, and two agents share it: the host and a slicer engine. The host owns the port only while every per-line mode register holds the all-ones "disabled" code and full-field mode is off. At any other time the engine owns the port. Host writes are then dropped, host reads return zero, the pointer does not move, and a sticky error flag records the refused access. Host read data and engine read data are both registered, so each arrives one cycle after its request.

Top module: `cfg_port`

## Requirements
- R1: After reset the pointer is 0, the error flag is 0, both read-valid outputs are 0 and both read-data outputs are 0.
- R2: `host_grant` is 1 exactly when every 8-bit field of `line_mode` equals 8'hFF and `full_field_en` is 0. Field i occupies bits [8i+7:8i].
- R3: A granted write stores `host_wdata` at the pointer's location, and the pointer advances by one on the next cycle.
- R4: A granted read presents the word at the pointer's location on `host_rdata`, with `host_rvalid` high, in the next cycle, and the pointer advances by one. `host_rvalid` is high in a cycle exactly when `host_rd` was high in the cycle before.
- R5: An advance from location DEPTH-1 takes the pointer to 0.
- R6: While the host is not granted, host writes change no RAM word, host reads return 0 with `host_rvalid` high, and the pointer holds its value.
- R7: Any host read or write while the host is not granted sets `access_err`, which then stays 1 until reset.
- R8: `host_ptr_clr` makes the pointer 0 on the next cycle and takes priority over an advance. An access in the same cycle still uses the old pointer location.
- R9: While the host is not granted, an engine read returns the word at `eng_addr` one cycle later with `eng_rvalid` high. While the host is granted, `eng_rvalid` stays 0.
- R10: A granted read and write in the same cycle stores the new word, returns the word held before the write, and advances the pointer by one location only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_mode | input | NUM_LINES*8 | Packed per-line mode codes |
| full_field_en | input | 1 | Full-field mode enable |
| host_wr | input | 1 | Host write strobe at the data register |
| host_rd | input | 1 | Host read strobe at the data register |
| host_wdata | input | DW | Host write data |
| host_ptr_clr | input | 1 | Pointer clear strobe |
| host_rdata | output | DW | Registered host read data |
| host_rvalid | output | 1 | Host read data valid |
| host_ptr | output | AW | Current pointer value |
| host_grant | output | 1 | Host owns the RAM port |
| access_err | output | 1 | Sticky refused-access flag |
| eng_rd | input | 1 | Engine read request |
| eng_addr | input | AW | Engine read address |
| eng_rdata | output | DW | Registered engine read data |
| eng_rvalid | output | 1 | Engine read data valid |

## Verification
A pointer clear and a host access can occur in the same cycle, and they compete for the next value of the pointer. The bench places a write and a clear on one edge at a nonzero pointer. It then expects the pointer to read 0, and expects the written word to appear at the old location when the table is read back. A read and a write on the same edge are also driven together. The bench checks that the read returns the old word and that the pointer moves by one location only.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int MODE_W = 8;
    localparam logic [MODE_W-1:0] MODE_OFF = 8'hFF;

    typedef enum logic {
        OWN_ENGINE = 1'b0,
        OWN_HOST   = 1'b1
    } port_owner_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic clr;
    } host_req_t;

    function automatic logic mode_is_off(input logic [MODE_W-1:0] code);
        return code == MODE_OFF;
    endfunction

endpackage

// File: rtl/cfg_gate.sv
module cfg_gate
    import cfg_port_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_LINES*MODE_W-1:0] line_mode,
    input  logic                        full_field_en,
    output port_owner_e                 owner
);
    logic [NUM_LINES-1:0] off_vec;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign off_vec[g] = mode_is_off(line_mode[g*MODE_W +: MODE_W]);
    end

    assign owner = (&off_vec && !full_field_en) ? OWN_HOST : OWN_ENGINE;
endmodule

// File: rtl/cfg_ptr.sv
module cfg_ptr
    import cfg_port_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  host_req_t   req,
    input  port_owner_e owner,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ptr_next;
    logic          step;

    assign step     = (owner == OWN_HOST) && (req.wr || req.rd);
    assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || req.clr) ptr <= '0;
        else if (step)      ptr <= ptr_next;
    end
endmodule

// File: rtl/cfg_ram.sv
module cfg_ram
    import cfg_port_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  port_owner_e   owner,
    input  host_req_t     req,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          eng_rd,
    input  logic [AW-1:0] eng_addr,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic [DW-1:0] eng_rdata,
    output logic          eng_rvalid
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] port_addr;
    logic          host_owns;

    assign host_owns = (owner == OWN_HOST);
    assign port_addr = host_owns ? host_addr : eng_addr;

    always_ff @(posedge clk) begin
        if (host_owns && req.wr) mem[port_addr] <= host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
            eng_rdata   <= '0;
            eng_rvalid  <= 1'b0;
        end else begin
            host_rvalid <= req.rd;
            if (req.rd) host_rdata <= host_owns ? mem[port_addr] : '0;
            eng_rvalid  <= eng_rd && !host_owns;
            if (eng_rd && !host_owns) eng_rdata <= mem[port_addr];
        end
    end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfg_port_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DEPTH     = 16,
    parameter int DW        = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINES*MODE_W-1:0] line_mode,
    input  logic                        full_field_en,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [DW-1:0]               host_wdata,
    input  logic                        host_ptr_clr,
    output logic [DW-1:0]               host_rdata,
    output logic                        host_rvalid,
    output logic [AW-1:0]               host_ptr,
    output logic                        host_grant,
    output logic                        access_err,
    input  logic                        eng_rd,
    input  logic [AW-1:0]               eng_addr,
    output logic [DW-1:0]               eng_rdata,
    output logic                        eng_rvalid
);
    port_owner_e owner;
    host_req_t   req;

    assign req.wr  = host_wr;
    assign req.rd  = host_rd;
    assign req.clr = host_ptr_clr;

    cfg_gate #(.NUM_LINES(NUM_LINES)) u_gate (
        .line_mode     (line_mode),
        .full_field_en (full_field_en),
        .owner         (owner)
    );

    cfg_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .owner (owner),
        .ptr   (host_ptr)
    );

    cfg_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk         (clk),
        .rst         (rst),
        .owner       (owner),
        .req         (req),
        .host_addr   (host_ptr),
        .host_wdata  (host_wdata),
        .eng_rd      (eng_rd),
        .eng_addr    (eng_addr),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .eng_rdata   (eng_rdata),
        .eng_rvalid  (eng_rvalid)
    );

    assign host_grant = (owner == OWN_HOST);

    always_ff @(posedge clk) begin
        if (rst)                                      access_err <= 1'b0;
        else if (!host_grant && (host_wr || host_rd)) access_err <= 1'b1;
    end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr,
    input logic          host_rd,
    input logic          host_ptr_clr,
    input logic [AW-1:0] host_ptr,
    input logic          host_grant,
    input logic          access_err,
    input logic [DW-1:0] host_rdata,
    input logic          host_rvalid,
    input logic          eng_rvalid
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        host_grant && (host_wr || host_rd) && !host_ptr_clr |=>
        host_ptr == (($past(host_ptr) == LAST) ? '0 : $past(host_ptr) + 1'b1)); // R3

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        host_ptr <= LAST); // R5

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !host_grant && !host_ptr_clr |=> $stable(host_ptr)); // R6

    AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (rst)
        !host_grant && host_rd |=> host_rvalid && host_rdata == '0); // R6

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        !host_grant && (host_wr || host_rd) |=> access_err); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        access_err |=> access_err); // R7

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        host_ptr_clr |=> host_ptr == '0); // R8

    AST_RVALID: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid); // R4

    AST_NO_RVALID: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid); // R4

    AST_ENG_QUIET: assert property (@(posedge clk) disable iff (rst)
        host_grant |=> !eng_rvalid); // R9
endmodule

bind cfg_port cfg_port_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_ptr_clr (host_ptr_clr),
    .host_ptr     (host_ptr),
    .host_grant   (host_grant),
    .access_err   (access_err),
    .host_rdata   (host_rdata),
    .host_rvalid  (host_rvalid),
    .eng_rvalid   (eng_rvalid)
);

// File: tb/cfg_port_bench.sv
module cfg_port_bench;
    localparam int NL    = 4;
    localparam int DEPTH = 12;
    localparam int DW    = 8;
    localparam int AW    = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NL*8-1:0] line_mode = '1;
    logic            full_field_en = 1'b0;
    logic            host_wr = 1'b0, host_rd = 1'b0, host_ptr_clr = 1'b0;
    logic [DW-1:0]   host_wdata = '0;
    logic [DW-1:0]   host_rdata;
    logic            host_rvalid, host_grant, access_err;
    logic [AW-1:0]   host_ptr;
    logic            eng_rd = 1'b0;
    logic [AW-1:0]   eng_addr = '0;
    logic [DW-1:0]   eng_rdata;
    logic            eng_rvalid;

    int checks = 0;
    int fails  = 0;
    int exp_ptr = 0;
    logic [DW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    cfg_port #(.NUM_LINES(NL), .DEPTH(DEPTH), .DW(DW)) u_cfg_port (.*);

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int adv(input int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    task automatic host_write(input logic [DW-1:0] d);
        host_wr = 1'b1; host_wdata = d;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic host_read();
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ptr", host_ptr, 0);
        check("R1 err", access_err, 0);
        check("R1 rvalid", host_rvalid, 0);
        check("R1 rdata", host_rdata, 0);
        check("R1 eng_rvalid", eng_rvalid, 0);
        check("R1 eng_rdata", eng_rdata, 0);

        // R2 gate sweep: every subset of lines off, both full-field states
        for (int ff = 0; ff < 2; ff++) begin
            for (int m = 0; m < (1 << NL); m++) begin
                for (int i = 0; i < NL; i++)
                    line_mode[i*8 +: 8] = m[i] ? 8'hFF : 8'(8'hFE - i);
                full_field_en = ff[0];
                #1;
                check("R2 grant", host_grant, (m == (1 << NL) - 1) && ff == 0);
            end
        end
        line_mode = '1; full_field_en = 1'b0;

        // R3 fill table, R5 wrap
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 8'((i * 37 + 5) & 8'hFF);
            host_write(model[i]);
            exp_ptr = adv(exp_ptr);
            check("R3 ptr after write", host_ptr, exp_ptr);
        end
        check("R5 wrap after fill", host_ptr, 0);

        // R4 read back past the end, R5 wrap
        for (int i = 0; i < DEPTH + 2; i++) begin
            host_read();
            check("R4 rvalid", host_rvalid, 1);
            check("R4 rdata", host_rdata, model[i % DEPTH]);
            exp_ptr = adv(exp_ptr);
            check("R4 ptr", host_ptr, exp_ptr);
        end
        tick();
        check("R4 rvalid low", host_rvalid, 0);

        // R6 R7 blocked by one line mode
        line_mode[8 +: 8] = 8'h03;
        #1;
        check("R2 blocked", host_grant, 0);
        host_write(8'hA5);
        check("R6 ptr hold", host_ptr, exp_ptr);
        check("R7 err set", access_err, 1);
        host_read();
        check("R6 blocked rdata", host_rdata, 0);
        check("R6 blocked rvalid", host_rvalid, 1);
        check("R6 ptr hold rd", host_ptr, exp_ptr);

        // R9 engine sweep while blocked (full-field as the cause)
        line_mode = '1; full_field_en = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            eng_rd = 1'b1; eng_addr = AW'(a);
            tick();
            check("R9 eng_rvalid", eng_rvalid, 1);
            check("R9 eng_rdata", eng_rdata, model[a]);
        end
        eng_rd = 1'b0;
        full_field_en = 1'b0;
        // R9 engine quiet while granted
        eng_rd = 1'b1; eng_addr = '0;
        tick();
        check("R9 eng quiet", eng_rvalid, 0);
        eng_rd = 1'b0;
        check("R7 err sticky", access_err, 1);

        // R8 clear alone, then clear with a write at nonzero pointer
        host_ptr_clr = 1'b1; tick(); host_ptr_clr = 1'b0;
        exp_ptr = 0;
        check("R8 clear", host_ptr, 0);
        for (int i = 0; i < 5; i++) begin host_read(); exp_ptr = adv(exp_ptr); end
        check("R8 ptr before", host_ptr, 5);
        host_ptr_clr = 1'b1; host_wr = 1'b1; host_wdata = 8'h3C;
        tick();
        host_ptr_clr = 1'b0; host_wr = 1'b0;
        model[5] = 8'h3C;
        exp_ptr = 0;
        check("R8 clear wins", host_ptr, 0);

        // R6 blocked write did not land, R8 write landed: full read-back
        for (int i = 0; i < DEPTH; i++) begin
            host_read();
            check("R6 R8 table", host_rdata, model[i]);
        end

        // R10 simultaneous read and write at location 2
        host_ptr_clr = 1'b1; tick(); host_ptr_clr = 1'b0;
        host_read(); host_read();
        host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'hC7;
        tick();
        host_rd = 1'b0; host_wr = 1'b0;
        check("R10 old data", host_rdata, model[2]);
        check("R10 single step", host_ptr, 3);
        model[2] = 8'hC7;
        line_mode[0 +: 8] = 8'h00;
        eng_rd = 1'b1; eng_addr = AW'(2);
        tick();
        eng_rd = 1'b0;
        check("R10 new data", eng_rdata, 8'hC7);

        // R1 reset clears sticky flag
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check("R1 err after reset", access_err, 0);
        check("R1 ptr after reset", host_ptr, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule